// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a synchronous host and an external asynchronous static RAM of 32K bytes. The host issues one read or one write at a time on a valid/ready handshake. The controller turns each request into a correctly timed strobe sequence on the memory's active-low chip enable, write enable and output enable. It also drives the 15-bit address and steers the 8-bit data bus, which is split into an output value, an output-enable and an input value so that a pad ring can build the tristate.

Every timing figure of the memory is given to the block in nanoseconds together with the clock period. The block rounds each figure up to a whole number of clocks. With the defaults (20 ns clock, 70 ns access, 55 ns write pulse, 30 ns data setup, 5 ns write recovery), a read keeps the memory selected for 4 clocks. A write has one clock of address setup, then a 3-clock strobe, then one clock of hold, then a recovery clock. Completion is a one-clock done pulse; for a read, the captured byte is presented in the same cycle as that pulse.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: During and after reset, until a request is accepted, reqReady is 1, sramCeN, sramWeN and sramOeN are all 1, sramDqOe is 0 and rspDone is 0.
- R2: A read holds sramCeN and sramOeN at 0 and sramWeN at 1 for exactly ceil(T_RC_NS/CLK_NS) consecutive clocks (4 by default), with sramAddr equal to the requested address.
- R3: The read result is the byte on sramDqIn during the last clock of that access window. It appears on rspRdata in the one clock where rspDone is 1, and rspDone is never high for two clocks in a row.
- R4: A write holds sramCeN and sramWeN at 0 together for exactly max(ceil(T_WP_NS/CLK_NS), ceil(T_DS_NS/CLK_NS)) clocks (3 by default). sramOeN stays 1 whenever sramWeN is 0.
- R5: For a write, sramAddr carries the request address for ADDR_SETUP_CYC clocks before the strobe starts and one clock after it ends. sramAddr never changes while sramCeN stays 0.
- R6: sramDqOe is 1 only during the write strobe and the one clock after it. While it is 1, sramDqOut holds the request's write byte and sramOeN is 1.
- R7: sramCeN stays 1 for at least ceil(T_WR_NS/CLK_NS)+1 clocks between the end of one cycle and the start of the next. reqReady is 0 while a cycle is in progress, and a reqValid raised during that time is ignored: it neither starts a cycle, nor produces a done pulse, nor changes memory.
- R8: A write also completes with a single rspDone pulse, one clock after its hold clock.
- R9: The 15-bit address reaches every byte location, including address 0 and address 0x7FFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Controller idle and able to take a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 15 | Byte address of the request |
| reqWdata | input | 8 | Byte to write |
| rspDone | output | 1 | One-clock completion pulse |
| rspRdata | output | 8 | Byte read, valid with rspDone after a read |
| sramCeN | output | 1 | Memory chip enable, active low |
| sramWeN | output | 1 | Memory write enable, active low |
| sramOeN | output | 1 | Memory output enable, active low |
| sramAddr | output | 15 | Memory address |
| sramDqOut | output | 8 | Byte driven toward the memory |
| sramDqOe | output | 1 | Enable for the host-side data driver |
| sramDqIn | input | 8 | Byte returned by the memory |

## Verification
The assertions assume that the host changes reqAddr, reqWdata and reqWrite only while reqValid is raised at a clock where reqReady is 1, or while the block is busy. They also assume that the memory returns a settled byte by the end of the access window. The stimulus drives every input half a clock away from the active edge and raises reqValid at a ready clock. A behavioural memory model supplies the read bytes and checks strobe lengths, setup, hold and recovery on the pins. One deliberate burst of reqValid is placed inside a busy read, to show that such a request is dropped.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  // Strobes handed from the sequencer to the datapath; all are registered.
  typedef struct packed {
    logic ceN;
    logic weN;
    logic oeN;
    logic dqDrive;
    logic capture;
    logic finish;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '{ceN: 1'b1, weN: 1'b1, oeN: 1'b1,
                                      dqDrive: 1'b0, capture: 1'b0, finish: 1'b0};

  typedef enum logic [2:0] {
    S_IDLE,
    S_READ,
    S_WSETUP,
    S_WSTROBE,
    S_WHOLD,
    S_RECOVER
  } ctrl_state_e;

  function automatic int nsToCycles(input int ns, input int clkNs);
    return (ns + clkNs - 1) / clkNs;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYC    = 4,
  parameter int STB_CYC   = 3,
  parameter int SETUP_CYC = 1,
  parameter int REC_CYC   = 1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output logic    accept,
  output strobe_t strb
);

  localparam int MAX_CYC = maxOf(maxOf(RD_CYC, STB_CYC), maxOf(SETUP_CYC, REC_CYC));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  ctrl_state_e state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;

  assign reqReady = (state == S_IDLE);
  assign accept   = reqReady && reqValid;

  // Step to the next phase once the current one has run its count.
  always_comb begin
    stateNext = state;
    cntNext   = cnt + 1'b1;
    unique case (state)
      S_IDLE: begin
        cntNext = '0;
        if (reqValid) stateNext = reqWrite ? S_WSETUP : S_READ;
      end
      S_READ:
        if (cnt == CNT_W'(RD_CYC - 1)) begin
          stateNext = S_RECOVER;
          cntNext   = '0;
        end
      S_WSETUP:
        if (cnt == CNT_W'(SETUP_CYC - 1)) begin
          stateNext = S_WSTROBE;
          cntNext   = '0;
        end
      S_WSTROBE:
        if (cnt == CNT_W'(STB_CYC - 1)) begin
          stateNext = S_WHOLD;
          cntNext   = '0;
        end
      S_WHOLD: begin
        stateNext = S_RECOVER;
        cntNext   = '0;
      end
      S_RECOVER:
        if (cnt == CNT_W'(REC_CYC - 1)) begin
          stateNext = S_IDLE;
          cntNext   = '0;
        end
      default: begin
        stateNext = S_IDLE;
        cntNext   = '0;
      end
    endcase
  end

  function automatic strobe_t decode(input ctrl_state_e st, input logic [CNT_W-1:0] c);
    strobe_t s;
    s = STROBE_IDLE;
    case (st)
      S_READ: begin
        s.ceN     = 1'b0;
        s.oeN     = 1'b0;
        s.capture = (c == CNT_W'(RD_CYC - 1));
        s.finish  = (c == CNT_W'(RD_CYC - 1));
      end
      S_WSTROBE: begin
        s.ceN     = 1'b0;
        s.weN     = 1'b0;
        s.dqDrive = 1'b1;
      end
      S_WHOLD: begin
        s.dqDrive = 1'b1;
        s.finish  = 1'b1;
      end
      default: s = STROBE_IDLE;
    endcase
    return s;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
      strb  <= STROBE_IDLE;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
      strb  <= decode(stateNext, cntNext);
    end
  end

  AST_IDLE_STROBES_OFF: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (strb.ceN && strb.weN && strb.oeN && !strb.dqDrive)); // R1

  AST_CAPTURE_WHILE_READING: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |-> (!strb.ceN && !strb.oeN && strb.weN)); // R3

  AST_FINISH_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish |=> !strb.finish); // R8

endmodule

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 15,
  parameter int DATA_W  = 8,
  parameter int STB_CYC = 3,
  parameter int REC_CYC = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accept,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspDone,
  output logic [DATA_W-1:0] rspRdata,
  output logic              sramCeN,
  output logic              sramWeN,
  output logic              sramOeN,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [DATA_W-1:0] sramDqOut,
  output logic              sramDqOe,
  input  logic [DATA_W-1:0] sramDqIn
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;

  // Address and write byte are held from acceptance until the next request.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
    end else if (accept) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspDone  <= 1'b0;
      rspRdata <= '0;
    end else begin
      rspDone <= strb.finish;
      if (strb.capture) rspRdata <= sramDqIn;
    end
  end

  assign sramCeN   = strb.ceN;
  assign sramWeN   = strb.weN;
  assign sramOeN   = strb.oeN;
  assign sramAddr  = addrQ;
  assign sramDqOut = wdataQ;
  assign sramDqOe  = strb.dqDrive;

  // Window counters watched by the timing assertions.
  localparam int GAP_MIN = REC_CYC + 1;
  localparam int WLC_W   = $clog2(STB_CYC + 1);
  localparam int GAP_W   = $clog2(GAP_MIN + 1);

  logic [WLC_W-1:0] weLowCnt;
  logic [GAP_W-1:0] ceHighCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      weLowCnt  <= '0;
      ceHighCnt <= GAP_W'(GAP_MIN);
    end else begin
      if (sramWeN) weLowCnt <= '0;
      else if (weLowCnt != WLC_W'(STB_CYC)) weLowCnt <= weLowCnt + 1'b1;
      if (!sramCeN) ceHighCnt <= '0;
      else if (ceHighCnt != GAP_W'(GAP_MIN)) ceHighCnt <= ceHighCnt + 1'b1;
    end
  end

  AST_WRITE_PULSE_LONG: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sramWeN) |-> (weLowCnt >= WLC_W'(STB_CYC))); // R4

  AST_OE_OFF_IN_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !sramWeN |-> sramOeN); // R4

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!sramCeN && $past(!sramCeN)) |-> $stable(sramAddr)); // R5

  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rstN)
    sramDqOe |-> sramOeN); // R6

  AST_RECOVERY_GAP: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sramCeN) |-> (ceHighCnt >= GAP_W'(GAP_MIN))); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone); // R3

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W         = 15,
  parameter int DATA_W         = 8,
  parameter int CLK_NS         = 20,
  parameter int T_RC_NS        = 70,
  parameter int T_WP_NS        = 55,
  parameter int T_DS_NS        = 30,
  parameter int T_WR_NS        = 5,
  parameter int ADDR_SETUP_CYC = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspDone,
  output logic [DATA_W-1:0] rspRdata,
  output logic              sramCeN,
  output logic              sramWeN,
  output logic              sramOeN,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [DATA_W-1:0] sramDqOut,
  output logic              sramDqOe,
  input  logic [DATA_W-1:0] sramDqIn
);

  localparam int RD_CYC  = maxOf(1, nsToCycles(T_RC_NS, CLK_NS));
  localparam int STB_CYC = maxOf(1, maxOf(nsToCycles(T_WP_NS, CLK_NS),
                                          nsToCycles(T_DS_NS, CLK_NS)));
  localparam int REC_CYC = maxOf(1, nsToCycles(T_WR_NS, CLK_NS));
  localparam int SET_CYC = maxOf(1, ADDR_SETUP_CYC);

  strobe_t strb;
  logic    accept;

  sram_ctrl_fsm #(
    .RD_CYC   (RD_CYC),
    .STB_CYC  (STB_CYC),
    .SETUP_CYC(SET_CYC),
    .REC_CYC  (REC_CYC)
  ) u_fsm (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .accept  (accept),
    .strb    (strb)
  );

  sram_ctrl_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .STB_CYC(STB_CYC),
    .REC_CYC(REC_CYC)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .accept   (accept),
    .strb     (strb),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .rspDone  (rspDone),
    .rspRdata (rspRdata),
    .sramCeN  (sramCeN),
    .sramWeN  (sramWeN),
    .sramOeN  (sramOeN),
    .sramAddr (sramAddr),
    .sramDqOut(sramDqOut),
    .sramDqOe (sramDqOe),
    .sramDqIn (sramDqIn)
  );

  AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!sramDqOe && sramCeN)); // R7

endmodule

// File: tb/sram_cycle_ctrl_bench.sv
module sram_cycle_ctrl_bench;

  localparam int RD_LEN  = 4;
  localparam int STB_LEN = 3;
  localparam int GAP_MIN = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic       reqReady;
  logic       reqWrite = 1'b0;
  logic [14:0] reqAddr = '0;
  logic [7:0] reqWdata = '0;
  logic       rspDone;
  logic [7:0] rspRdata;
  logic       sramCeN, sramWeN, sramOeN, sramDqOe;
  logic [14:0] sramAddr;
  logic [7:0] sramDqOut;
  logic [7:0] sramDqIn;

  always #10 clk = ~clk;

  sram_cycle_ctrl u_sram_cycle_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspDone(rspDone), .rspRdata(rspRdata), .sramCeN(sramCeN),
    .sramWeN(sramWeN), .sramOeN(sramOeN), .sramAddr(sramAddr),
    .sramDqOut(sramDqOut), .sramDqOe(sramDqOe), .sramDqIn(sramDqIn)
  );

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Behavioural memory model
  logic [7:0] mem [int];
  logic [7:0] shadow [int];

  always_comb begin
    sramDqIn = 8'h00;
    if (!sramCeN && !sramOeN && sramWeN)
      sramDqIn = mem.exists(int'(sramAddr)) ? mem[int'(sramAddr)] : 8'hFF;
  end

  bit prevWr = 0;
  bit prevCeLow = 0;
  bit wasRead = 0;
  int wrLow = 0;
  int ceLow = 0;
  int ceHigh = 100;
  logic [14:0] prevAddr = '0;
  logic [14:0] stbAddr = '0;
  logic [7:0] stbData = '0;

  always @(negedge clk) begin
    if (rstN) begin
      bit wr;
      wr = !sramCeN && !sramWeN;
      if (!sramWeN && !sramOeN) check(0, "R4 oe low in write", 0, 1);
      if (sramDqOe && !sramOeN) check(0, "R6 bus fight", 0, 1);
      if (sramDqOe && !(wr || prevWr)) check(0, "R6 drive outside window", 1, 0);
      if (wr && !prevWr) begin
        check(sramAddr == prevAddr, "R5 address setup", sramAddr, prevAddr);
        check(sramDqOe == 1'b1, "R6 drive at strobe start", sramDqOe, 1);
        stbAddr = sramAddr;
        stbData = sramDqOut;
        wrLow = 1;
      end else if (wr) begin
        wrLow++;
        if (sramAddr != stbAddr || sramDqOut != stbData || !sramDqOe)
          check(0, "R5 address/data moved in strobe", sramAddr, stbAddr);
      end
      if (!wr && prevWr) begin
        check(wrLow == STB_LEN, "R4 strobe length", wrLow, STB_LEN);
        check(sramAddr == stbAddr && sramDqOe && sramDqOut == stbData,
              "R5 hold after strobe", sramAddr, stbAddr);
        mem[int'(stbAddr)] = stbData;
      end
      if (!sramCeN) begin
        if (!prevCeLow) begin
          check(ceHigh >= GAP_MIN, "R7 recovery gap", ceHigh, GAP_MIN);
          ceLow = 0;
          wasRead = 0;
        end
        ceLow++;
        if (!sramOeN) begin
          wasRead = 1;
          if (!sramWeN) check(0, "R2 we low in read", 0, 1);
        end
        ceHigh = 0;
      end else begin
        if (prevCeLow && wasRead) check(ceLow == RD_LEN, "R2 read window", ceLow, RD_LEN);
        ceHigh++;
      end
      prevCeLow = !sramCeN;
      prevWr = wr;
      prevAddr = sramAddr;
    end
  end

  // Scoreboard
  typedef struct {
    bit isRead;
    logic [14:0] addr;
    logic [7:0] data;
  } exp_t;
  exp_t expQ[$];
  bit prevDone = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (rspDone && prevDone) check(0, "R3 done longer than one clock", 2, 1);
      if (rspDone) begin
        if (expQ.size() == 0) begin
          check(0, "R7 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          if (e.isRead) check(rspRdata == e.data, "R3 read data", rspRdata, e.data);
          else check(1, "R8 write done", 1, 1);
        end
      end
      prevDone = rspDone;
    end
  end

  task automatic doReq(input bit wr, input logic [14:0] a, input logic [7:0] d);
    exp_t e;
    do @(negedge clk); while (!reqReady);
    reqValid = 1'b1;
    reqWrite = wr;
    reqAddr  = a;
    reqWdata = d;
    e.isRead = !wr;
    e.addr   = a;
    if (wr) begin
      shadow[int'(a)] = d;
      e.data = d;
    end else begin
      e.data = shadow.exists(int'(a)) ? shadow[int'(a)] : 8'hFF;
    end
    expQ.push_back(e);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(reqReady && sramCeN && sramWeN && sramOeN && !sramDqOe && !rspDone,
          "R1 state in reset", {reqReady, sramCeN, sramWeN, sramOeN, sramDqOe, rspDone}, 6'b111100);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady && sramCeN && sramWeN && sramOeN && !sramDqOe && !rspDone,
          "R1 idle after reset", {reqReady, sramCeN, sramWeN, sramOeN, sramDqOe, rspDone}, 6'b111100);

    // R9 boundary addresses, plus a middle one
    doReq(1, 15'h0000, 8'hA5);
    doReq(1, 15'h7FFF, 8'h3C);
    doReq(1, 15'h1234, 8'h5A);
    doReq(0, 15'h0000, 8'h00);
    doReq(0, 15'h7FFF, 8'h00);
    doReq(0, 15'h1234, 8'h00);
    // unwritten location and overwrite
    doReq(0, 15'h0055, 8'h00);
    doReq(1, 15'h1234, 8'hC3);
    doReq(0, 15'h1234, 8'h00);
    // alternating patterns back to back
    for (int i = 0; i < 6; i++) begin
      doReq(1, 15'(16'h0100 + i * 16'h0811), 8'(8'h11 * i + 8'h0F));
      doReq(0, 15'(16'h0100 + i * 16'h0811), 8'h00);
    end
    for (int i = 0; i < 4; i++) doReq(0, 15'h7FFF, 8'h00);

    // R7 request raised while busy must be ignored
    doReq(1, 15'h0200, 8'h77);
    doReq(0, 15'h0200, 8'h00);
    reqValid = 1'b1;
    reqWrite = 1'b1;
    reqAddr  = 15'h0200;
    reqWdata = 8'h99;
    check(reqReady == 1'b0, "R7 busy not ready", reqReady, 0);
    @(negedge clk);
    check(reqReady == 1'b0, "R7 busy not ready", reqReady, 0);
    @(negedge clk);
    reqValid = 1'b0;
    doReq(0, 15'h0200, 8'h00);

    for (int i = 0; i < 200 && expQ.size() != 0; i++) @(negedge clk);
    repeat (8) @(negedge clk);
    check(expQ.size() == 0, "R8 all cycles completed", expQ.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      check(0, "watchdog expired", 0, 1);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule